// File: doc/BRIEF.md
# Serial Flash Identification Probe

This block reads the identification bytes of a serial flash and decides whether the part is the one that was expected. A single-cycle `start` pulse makes it drive its own SPI frame in mode 0. It sends the read-identification opcode, then clocks in three or four response bytes, as chosen by a parameter. Chip select is held low for the whole frame.

When the frame ends, the block forms a manufacturer ID and a device ID. A leading continuation code 0x7F widens the manufacturer ID to two bytes. The block checks odd parity on the vendor bytes. It then compares the decoded pair with an expected pair on configuration inputs. The comparison allows two reserved wildcard values, one for "any device of this vendor" and one for "any vendor that answers".

The results are registered. They stay as they are until the next accepted `start`, so system software or a boot sequencer can read them at leisure.

Top module: `jedec_id_probe`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, and `done`, `match` and `parity_warn` are 0.
- R2: A probe is one frame with `spi_cs_n` low throughout. The frame has exactly 8*(1+RESP_BYTES) rising edges of `spi_sclk`. The first 8 rising edges carry opcode 0x9F on `spi_mosi`, MSB first. In mode 0 `spi_mosi` changes while `spi_sclk` is low, and `spi_miso` is sampled on each rising edge. `spi_mosi` is 0 while response bits are clocked in. `spi_sclk` is low whenever `spi_cs_n` is high.
- R3: When response byte 0 (the first byte received, MSB first) is not 0x7F, `mfr_id` = {8'h00, byte0} and `dev_id` = {byte1, byte2}.
- R4: When byte 0 is 0x7F, `mfr_id` = {8'h7F, byte1}. `dev_id` = {byte2, byte3} with RESP_BYTES=4, or {8'h00, byte2} with RESP_BYTES=3.
- R5: `parity_warn` is 1 when byte 0 has an even number of ones. It is also 1 when byte 0 is 0x7F and byte 1 has an even number of ones. A warning does not by itself clear `match`.
- R6: `match` is 1 when `mfr_id` equals `exp_mfr` and `dev_id` equals `exp_dev`.
- R7: `match` is also 1 when `mfr_id` equals `exp_mfr` and `exp_dev` equals GENERIC_DEV (default 16'hFFFF).
- R8: `match` is also 1 when `exp_mfr` equals GENERIC_MFR (default 16'hFFFE) and `mfr_id` is not 16'h00FF. In every other case `match` is 0.
- R9: `done` rises once the frame has ended. From then on, `done`, `match`, `parity_warn`, `mfr_id` and `dev_id` hold steady, even if `exp_mfr`, `exp_dev` or `spi_miso` change, until the next `start`. An accepted `start` clears `done`, `match` and `parity_warn`.
- R10: A `start` pulse that arrives while a frame is in progress has no effect. The frame keeps its length and does not restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run a probe |
| exp_mfr | input | 16 | Expected manufacturer ID or the vendor wildcard |
| exp_dev | input | 16 | Expected device ID or the device wildcard |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| done | output | 1 | Probe finished, results valid |
| match | output | 1 | Decoded IDs accepted by the match rule |
| parity_warn | output | 1 | Odd-parity violation on a vendor byte |
| mfr_id | output | 16 | Decoded manufacturer ID |
| dev_id | output | 16 | Decoded device ID |

## Verification
The hardest cases to reach are the continuation-prefixed answers with a bad second byte, and a second `start` that lands in the middle of a frame. The bench reaches them with a small flash responder model that counts clock edges, captures the opcode, and shifts out a programmable identification word. The bench pulses `start` again part way through a frame and then checks that the edge count still equals one full frame. It drives a 0x7F-prefixed word with an even-weight second byte, and checks both the warning and the match. A second instance built for three response bytes covers the narrower continuation format.

// File: rtl/jedec_id_probe.sv
module jedec_id_probe #(
  parameter int          RESP_BYTES  = 4,
  parameter int          HALF_PERIOD = 2,
  parameter logic [15:0] GENERIC_MFR = 16'hFFFE,
  parameter logic [15:0] GENERIC_DEV = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] exp_mfr,
  input  logic [15:0] exp_dev,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        done,
  output logic        match,
  output logic        parity_warn,
  output logic [15:0] mfr_id,
  output logic [15:0] dev_id
);
  localparam int RX_W  = 8 * RESP_BYTES;
  localparam int TOTAL = 8 * (RESP_BYTES + 1);
  localparam int BW    = $clog2(TOTAL + 1);
  localparam int DW    = $clog2(HALF_PERIOD + 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_FIN} state_t;

  state_t          state;
  logic [7:0]      tx;
  logic [RX_W-1:0] rx;
  logic [BW-1:0]   bits;
  logic [DW-1:0]   div;

  logic [7:0]  b0, b1, b2, b3;
  logic        cont, par_bad, hit;
  logic [15:0] mfr_d, dev_d;

  assign b0 = rx[RX_W-1 -: 8];
  assign b1 = rx[RX_W-9 -: 8];
  assign b2 = rx[RX_W-17 -: 8];
  assign b3 = (RESP_BYTES == 4) ? rx[7:0] : 8'h00;

  assign cont    = (b0 == 8'h7F);
  assign mfr_d   = cont ? {b0, b1} : {8'h00, b0};
  assign dev_d   = cont ? ((RESP_BYTES == 4) ? {b2, b3} : {8'h00, b2}) : {b1, b2};
  assign par_bad = ~(^b0) | (cont & ~(^b1));
  assign hit     = ((mfr_d == exp_mfr) && (dev_d == exp_dev)) ||
                   ((mfr_d == exp_mfr) && (exp_dev == GENERIC_DEV)) ||
                   ((exp_mfr == GENERIC_MFR) && (mfr_d != 16'h00FF));

  assign spi_mosi = tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      spi_cs_n    <= 1'b1;
      spi_sclk    <= 1'b0;
      tx          <= '0;
      rx          <= '0;
      bits        <= '0;
      div         <= '0;
      done        <= 1'b0;
      match       <= 1'b0;
      parity_warn <= 1'b0;
      mfr_id      <= '0;
      dev_id      <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state       <= S_XFER;
          spi_cs_n    <= 1'b0;
          tx          <= 8'h9F;
          bits        <= '0;
          div         <= '0;
          done        <= 1'b0;
          match       <= 1'b0;
          parity_warn <= 1'b0;
        end
        S_XFER: begin
          if (div == DW'(HALF_PERIOD - 1)) begin
            div      <= '0;
            spi_sclk <= ~spi_sclk;
            if (!spi_sclk) begin
              if (bits >= BW'(8)) rx <= {rx[RX_W-2:0], spi_miso};
            end else begin
              tx <= {tx[6:0], 1'b0};
              if (bits == BW'(TOTAL - 1)) state <= S_FIN;
              else bits <= bits + 1'b1;
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        S_FIN: begin
          state       <= S_IDLE;
          spi_cs_n    <= 1'b1;
          done        <= 1'b1;
          match       <= hit;
          parity_warn <= par_bad;
          mfr_id      <= mfr_d;
          dev_id      <= dev_d;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/jedec_id_probe_checker.sv
module jedec_id_probe_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        spi_sclk,
  input logic        spi_cs_n,
  input logic        done,
  input logic        match,
  input logic        parity_warn,
  input logic [15:0] mfr_id,
  input logic [15:0] dev_id
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R2
  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !done); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(match) && $stable(parity_warn) &&
                          $stable(mfr_id) && $stable(dev_id))); // R9
  AST_PREFIX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mfr_id[15:8] != 8'h00) |-> (mfr_id[15:8] == 8'h7F)); // R4
  AST_PLAIN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mfr_id[15:8] == 8'h00) |-> (parity_warn == ~(^mfr_id[7:0]))); // R5
endmodule

bind jedec_id_probe jedec_id_probe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .spi_sclk(spi_sclk),
  .spi_cs_n(spi_cs_n), .done(done), .match(match),
  .parity_warn(parity_warn), .mfr_id(mfr_id), .dev_id(dev_id)
);

// File: tb/jedec_id_probe_test.sv
module flash_stub #(parameter int N = 4) (
  input  logic         sclk,
  input  logic         cs_n,
  input  logic         mosi,
  output logic         miso,
  input  logic [8*N-1:0] resp,
  output logic [7:0]   op,
  output int           edges,
  output logic         mosi_seen
);
  initial begin edges = 0; op = 0; mosi_seen = 0; end
  always @(posedge sclk or negedge cs_n) begin
    if (!sclk) begin
      edges     <= 0;
      op        <= 8'h00;
      mosi_seen <= 1'b0;
    end else begin
      if (edges < 8) op <= {op[6:0], mosi};
      else if (mosi) mosi_seen <= 1'b1;
      edges <= edges + 1;
    end
  end
  assign miso = (!cs_n && edges >= 8 && edges < 8 + 8*N) ? resp[8*N-1-(edges-8)] : 1'b0;
endmodule

module jedec_id_probe_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] exp_mfr = 0, exp_dev = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic sclk4, cs4, mosi4, miso4, done4, match4, warn4;
  logic [15:0] mfr4, dev4;
  logic [31:0] resp4 = 0;
  logic [7:0] op4; int edges4; logic mhi4;

  logic sclk3, cs3, mosi3, miso3, done3, match3, warn3;
  logic [15:0] mfr3, dev3;
  logic [23:0] resp3 = 0;
  logic [7:0] op3; int edges3; logic mhi3;

  jedec_id_probe #(.RESP_BYTES(4)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_mfr(exp_mfr), .exp_dev(exp_dev),
    .spi_sclk(sclk4), .spi_cs_n(cs4), .spi_mosi(mosi4), .spi_miso(miso4),
    .done(done4), .match(match4), .parity_warn(warn4), .mfr_id(mfr4), .dev_id(dev4));
  flash_stub #(.N(4)) fl4 (.sclk(sclk4), .cs_n(cs4), .mosi(mosi4), .miso(miso4),
    .resp(resp4), .op(op4), .edges(edges4), .mosi_seen(mhi4));

  jedec_id_probe #(.RESP_BYTES(3)) uut_b3 (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_mfr(exp_mfr), .exp_dev(exp_dev),
    .spi_sclk(sclk3), .spi_cs_n(cs3), .spi_mosi(mosi3), .spi_miso(miso3),
    .done(done3), .match(match3), .parity_warn(warn3), .mfr_id(mfr3), .dev_id(dev3));
  flash_stub #(.N(3)) fl3 (.sclk(sclk3), .cs_n(cs3), .mosi(mosi3), .miso(miso3),
    .resp(resp3), .op(op3), .edges(edges3), .mosi_seen(mhi3));

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic run_probe(input logic [15:0] em, input logic [15:0] ed);
    exp_mfr = em; exp_dev = ed;
    pulse_start();
    for (int i = 0; i < 2000 && !(done4 && done3); i++) @(negedge clk);
    if (!(done4 && done3)) chk(0, "watchdog", 0, 1);
  endtask

  task automatic t_reset();
    chk(cs4 == 1 && cs3 == 1, "R1 cs_n", {cs4, cs3}, 2'b11);
    chk(sclk4 == 0 && sclk3 == 0, "R1 sclk", {sclk4, sclk3}, 0);
    chk({done4, match4, warn4} == 0, "R1 flags", {done4, match4, warn4}, 0);
  endtask

  task automatic t_plain();
    resp4 = 32'hEF40_1800; resp3 = 24'hC2_2016;
    run_probe(16'h00EF, 16'h4018);
    chk(op4 == 8'h9F && op3 == 8'h9F, "R2 opcode", {op4, op3}, 16'h9F9F);
    chk(edges4 == 40, "R2 edges4", edges4, 40);
    chk(edges3 == 32, "R2 edges3", edges3, 32);
    chk(!mhi4 && !mhi3, "R2 mosi low", {mhi4, mhi3}, 0);
    chk(mfr4 == 16'h00EF && dev4 == 16'h4018, "R3 ids4", {mfr4, dev4}, 32'h00EF4018);
    chk(mfr3 == 16'h00C2 && dev3 == 16'h2016, "R3 ids3", {mfr3, dev3}, 32'h00C22016);
    chk(match4 == 1 && warn4 == 0, "R6 exact", {match4, warn4}, 2'b10);
    chk(match3 == 0, "R8 no match3", match3, 0);
  endtask

  task automatic t_mismatch_and_dev_wild();
    run_probe(16'h00EF, 16'h4019);
    chk(match4 == 0, "R8 dev mismatch", match4, 0);
    run_probe(16'h00EF, 16'hFFFF);
    chk(match4 == 1, "R7 dev wildcard", match4, 1);
    run_probe(16'h00EE, 16'hFFFF);
    chk(match4 == 0, "R7 wrong vendor", match4, 0);
  endtask

  task automatic t_cont();
    resp4 = 32'h7F9D_1234; resp3 = 24'h7F9D_55;
    run_probe(16'h7F9D, 16'h1234);
    chk(mfr4 == 16'h7F9D && dev4 == 16'h1234, "R4 ids4", {mfr4, dev4}, 32'h7F9D1234);
    chk(mfr3 == 16'h7F9D && dev3 == 16'h0055, "R4 ids3", {mfr3, dev3}, 32'h7F9D0055);
    chk(match4 == 1 && warn4 == 0, "R6 cont exact", {match4, warn4}, 2'b10);
  endtask

  task automatic t_parity();
    resp4 = 32'h7F9C_1234; resp3 = 24'h1E_0000;
    run_probe(16'h7F9C, 16'h1234);
    chk(warn4 == 1 && match4 == 1, "R5 cont byte1 warn", {warn4, match4}, 2'b11);
    chk(warn3 == 1, "R5 byte0 warn", warn3, 1);
  endtask

  task automatic t_mfr_wild();
    resp4 = 32'hEF40_1800; resp3 = 24'hFF_FFFF;
    run_probe(16'hFFFE, 16'h0000);
    chk(match4 == 1, "R8 vendor wildcard", match4, 1);
    chk(match3 == 0 && mfr3 == 16'h00FF, "R8 blank flash", {match3, mfr3}, 17'h000FF);
  endtask

  task automatic t_hold();
    logic [15:0] m0, d0;
    logic mt;
    m0 = mfr4; d0 = dev4; mt = match4;
    exp_mfr = 16'h1234; exp_dev = 16'h5678; resp4 = 32'h0102_0304;
    repeat (20) @(negedge clk);
    chk(done4 && mfr4 == m0 && dev4 == d0 && match4 == mt, "R9 hold", {mfr4, dev4}, {m0, d0});
    pulse_start();
    chk(done4 == 0 && match4 == 0, "R9 start clears", {done4, match4}, 0);
    for (int i = 0; i < 2000 && !done4; i++) @(negedge clk);
  endtask

  task automatic t_busy_start();
    resp4 = 32'hEF40_1800;
    exp_mfr = 16'h00EF; exp_dev = 16'h4018;
    pulse_start();
    repeat (60) @(negedge clk);
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();
    for (int i = 0; i < 2000 && !(done4 && done3); i++) @(negedge clk);
    chk(edges4 == 40 && done4, "R10 frame length", edges4, 40);
    chk(mfr4 == 16'h00EF && dev4 == 16'h4018, "R10 result", {mfr4, dev4}, 32'h00EF4018);
    repeat (10) @(negedge clk);
    chk(done4 == 1 && cs4 == 1, "R10 no restart", {done4, cs4}, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_plain();
    t_mismatch_and_dev_wild();
    t_cont();
    t_parity();
    t_mfr_wild();
    t_hold();
    t_busy_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule